// File: doc/BRIEF.md
# Multi-Channel Activity Monitor with Watermark Interrupts

This block watches the traffic of several independent channels. Each channel owns an accumulator that adds a programmable weight for every event pulse it receives. A shared millisecond tick drives a common sampling timer. When a sampling period closes, every running channel copies its accumulated count aside, restarts the accumulator, and spends one evaluation cycle on that count. In that cycle it updates an exponentially smoothed average, compares the count against an upper and a lower watermark, and compares the new average against a second pair of watermarks.

A watermark breach on the raw count raises a flag only after it has repeated for a programmed number of consecutive periods. Above and below each have their own run counter. The interrupt output is the OR of every flag whose enable is set. A global pending word shows which channels are currently interrupting.

Each channel's state machine has three states. The states are CH_OFF (stopped), CH_RUN (accumulating) and CH_EVAL (one-cycle evaluation). Its transitions are:
- start: CH_OFF to CH_RUN, on a control write with the enable bit set.
- sample: CH_RUN to CH_EVAL, on a period end while periodic sampling is enabled.
- resume: CH_EVAL back to CH_RUN.
- stop: CH_RUN or CH_EVAL to CH_OFF, on a control write with the enable bit clear.

Software programs the block through a flat register port. Global registers sit in region 0. Channel c sits in region c+1, with the region taken from address bits [11:8] and the register offset from bits [7:0].

Top module: `am_activity_monitor`

## Requirements
- R1: After reset the interrupt output, the pending word and every readable register are zero.
- R2: Each event pulse on a running channel adds its count weight (channel offset 0x18) to the accumulator. The period register (global offset 0x04) holds the period length minus one, so a period closes on the (P+1)-th millisecond tick after that register was written.
- R3: At each period close the average (channel offset 0x20) becomes avg + ((count - avg) >>> (K+1)), computed signed, where K is control bits [12:10] (a window of 2^(K+1) periods). The average is loaded from the initial-average register (offset 0x0C) when the channel goes from stopped to enabled (control bit 31).
- R4: With control bit 30 set, a count strictly above the upper watermark (offset 0x04) for N+1 consecutive periods sets status bit 31, where N is control bits [28:26]. The run counter then restarts.
- R5: With control bit 29 set, a count strictly below the lower watermark (offset 0x08) for M+1 consecutive periods sets status bit 30, where M is control bits [25:23]. Any period without that breach resets the run to zero.
- R6: With control bit 21 set, a new average above the average-upper watermark (offset 0x10) sets status bit 29. With control bit 20 set, a new average below the average-lower watermark (offset 0x14) sets status bit 28.
- R7: Writing ones to the status register (offset 0x24) clears those bits; all ones clears every flag. The interrupt output is high while any status bit 31/30/29/28 is set together with its enable 30/29/21/20.
- R8: Bit c of the pending output and of the global status register (global offset 0x00) equals the interrupt condition of channel c.
- R9: Writing zero to a channel's control register stops it. Its events and period ends are then ignored, its average is held, its flags are kept, and it raises no interrupt.
- R10: While control bit 18 (periodic sampling) is clear, period ends leave an enabled channel's average and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Register address: region in [11:8], offset in [7:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ev_pulse | input | NUM_CH | One event pulse per channel per cycle |
| irq | output | 1 | OR of all channel interrupt conditions |
| chan_pending | output | NUM_CH | Per-channel interrupt condition |

## Verification
The block reacts on three different time scales. A register read is combinational, so the bench samples it in the same cycle, just after the address settles. An event pulse updates the accumulator at the next edge. The closing millisecond tick takes three edges to show up in the results: one edge for the timer's registered period-end pulse, one for the channel's move into CH_EVAL, and one for the average, the run counters and the status flags. The bench therefore waits four full cycles after each tick before its scoreboard monitor samples, and it checks that a single tick of a two-tick period changes nothing.

// File: rtl/am_pkg.sv
package am_pkg;

    localparam int DATA_W = 32;

    // channel register offsets
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_UP_WM  = 8'h04;
    localparam logic [7:0] OFF_LO_WM  = 8'h08;
    localparam logic [7:0] OFF_INIT   = 8'h0C;
    localparam logic [7:0] OFF_AUP_WM = 8'h10;
    localparam logic [7:0] OFF_ALO_WM = 8'h14;
    localparam logic [7:0] OFF_WEIGHT = 8'h18;
    localparam logic [7:0] OFF_AVG    = 8'h20;
    localparam logic [7:0] OFF_STAT   = 8'h24;

    // global register offsets
    localparam logic [7:0] GOFF_PEND   = 8'h00;
    localparam logic [7:0] GOFF_PERIOD = 8'h04;

    // control fields
    localparam int B_EN       = 31;
    localparam int B_CUP_EN   = 30;
    localparam int B_CDN_EN   = 29;
    localparam int B_AUP_EN   = 21;
    localparam int B_ADN_EN   = 20;
    localparam int B_PERIODIC = 18;
    localparam int CUP_LSB    = 26;
    localparam int CDN_LSB    = 23;
    localparam int RUN_W      = 3;
    localparam int K_LSB      = 10;
    localparam int K_W        = 3;

    // status flags live in bits 31..28; stored as a 4-bit vector
    localparam int FLAG_LSB = 28;
    localparam int F_CUP    = 3;
    localparam int F_CDN    = 2;
    localparam int F_AUP    = 1;
    localparam int F_ADN    = 0;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_EVAL = 2'd2
    } ch_state_e;

endpackage

// File: rtl/am_period_timer.sv
module am_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_wdata,
    input  logic             ms_tick,
    output logic             period_end,
    output logic [PER_W-1:0] period_q
);

    logic [PER_W-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            tick_cnt   <= '0;
            period_end <= 1'b0;
        end else begin
            period_end <= 1'b0;
            if (per_wr) begin
                period_q <= per_wdata;
                tick_cnt <= '0;
            end else if (ms_tick) begin
                if (tick_cnt == period_q) begin
                    tick_cnt   <= '0;
                    period_end <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tick_cnt <= period_q) else $error("tick count past period"); // R2
    AST_END_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n) period_end |-> $past(ms_tick)) else $error("period end without tick"); // R2

endmodule

// File: rtl/am_channel.sv
module am_channel
    import am_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [7:0]    offset,
    input  logic [DW-1:0] wdata,
    input  logic          ev,
    input  logic          period_end,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    ch_state_e state, nxt;

    logic [DW-1:0]    ctrl_q, up_wm, lo_wm, init_q, aup_wm, alo_wm, weight_q;
    logic [DW-1:0]    avg_q, acc_q, sample_q;
    logic [RUN_W-1:0] up_run, dn_run, up_run_n, dn_run_n;
    logic [3:0]       flags_q, set_bits, flag_mask;

    wire ctrl_wr = wr && (offset == OFF_CTRL);
    wire stat_wr = wr && (offset == OFF_STAT);
    wire [RUN_W-1:0] up_num = ctrl_q[CUP_LSB +: RUN_W];
    wire [RUN_W-1:0] dn_num = ctrl_q[CDN_LSB +: RUN_W];
    wire [K_W:0]     shamt  = {1'b0, ctrl_q[K_LSB +: K_W]} + 1'b1;
    wire sample_now = (state == CH_RUN) && period_end && ctrl_q[B_PERIODIC];

    // saturating accumulation
    logic [DW:0]   acc_sum;
    logic [DW-1:0] acc_inc;
    assign acc_sum = {1'b0, acc_q} + {1'b0, weight_q};
    assign acc_inc = acc_sum[DW] ? '1 : acc_sum[DW-1:0];

    // signed smoothing step
    logic signed [DW:0] diff, step, avg_sum;
    logic [DW-1:0]      avg_nxt;
    assign diff    = $signed({1'b0, sample_q}) - $signed({1'b0, avg_q});
    assign step    = diff >>> shamt;
    assign avg_sum = $signed({1'b0, avg_q}) + step;
    assign avg_nxt = avg_sum[DW-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF:  if (ctrl_wr && wdata[B_EN]) nxt = CH_RUN;
            CH_RUN:  if (ctrl_wr && !wdata[B_EN]) nxt = CH_OFF;
                     else if (sample_now)         nxt = CH_EVAL;
            CH_EVAL: if (ctrl_wr && !wdata[B_EN]) nxt = CH_OFF;
                     else                         nxt = CH_RUN;
            default: nxt = CH_OFF;
        endcase
    end

    // evaluation of one closed period
    always_comb begin
        set_bits = '0;
        up_run_n = up_run;
        dn_run_n = dn_run;
        if (state == CH_EVAL) begin
            if (ctrl_q[B_CUP_EN] && (sample_q > up_wm)) begin
                if (up_run == up_num) begin
                    set_bits[F_CUP] = 1'b1;
                    up_run_n        = '0;
                end else begin
                    up_run_n = up_run + 1'b1;
                end
            end else begin
                up_run_n = '0;
            end
            if (ctrl_q[B_CDN_EN] && (sample_q < lo_wm)) begin
                if (dn_run == dn_num) begin
                    set_bits[F_CDN] = 1'b1;
                    dn_run_n        = '0;
                end else begin
                    dn_run_n = dn_run + 1'b1;
                end
            end else begin
                dn_run_n = '0;
            end
            if (ctrl_q[B_AUP_EN] && (avg_nxt > aup_wm)) set_bits[F_AUP] = 1'b1;
            if (ctrl_q[B_ADN_EN] && (avg_nxt < alo_wm)) set_bits[F_ADN] = 1'b1;
        end
    end

    // datapath and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            up_wm    <= '0;
            lo_wm    <= '0;
            init_q   <= '0;
            aup_wm   <= '0;
            alo_wm   <= '0;
            weight_q <= '0;
            avg_q    <= '0;
            acc_q    <= '0;
            sample_q <= '0;
            up_run   <= '0;
            dn_run   <= '0;
            flags_q  <= '0;
        end else begin
            if (wr) begin
                case (offset)
                    OFF_UP_WM:  up_wm    <= wdata;
                    OFF_LO_WM:  lo_wm    <= wdata;
                    OFF_INIT:   init_q   <= wdata;
                    OFF_AUP_WM: aup_wm   <= wdata;
                    OFF_ALO_WM: alo_wm   <= wdata;
                    OFF_WEIGHT: weight_q <= wdata;
                    default: ;
                endcase
            end

            if (sample_now) begin
                sample_q <= acc_q;
                acc_q    <= ev ? weight_q : '0;
            end else if ((state != CH_OFF) && ev) begin
                acc_q <= acc_inc;
            end

            if (state == CH_EVAL) avg_q <= avg_nxt;
            up_run <= up_run_n;
            dn_run <= dn_run_n;

            flags_q <= (flags_q & ~(stat_wr ? wdata[FLAG_LSB +: 4] : 4'b0)) | set_bits;

            if (ctrl_wr) begin
                ctrl_q <= wdata;
                up_run <= '0;
                dn_run <= '0;
                if (!wdata[B_EN]) acc_q <= '0;
                if (wdata[B_EN] && (state == CH_OFF)) avg_q <= init_q;
            end
        end
    end

    assign flag_mask = {ctrl_q[B_CUP_EN], ctrl_q[B_CDN_EN], ctrl_q[B_AUP_EN], ctrl_q[B_ADN_EN]};
    assign irq       = |(flags_q & flag_mask);

    always_comb begin
        case (offset)
            OFF_CTRL:   rdata = ctrl_q;
            OFF_UP_WM:  rdata = up_wm;
            OFF_LO_WM:  rdata = lo_wm;
            OFF_INIT:   rdata = init_q;
            OFF_AUP_WM: rdata = aup_wm;
            OFF_ALO_WM: rdata = alo_wm;
            OFF_WEIGHT: rdata = weight_q;
            OFF_AVG:    rdata = avg_q;
            OFF_STAT:   rdata = {flags_q, {FLAG_LSB{1'b0}}};
            default:    rdata = '0;
        endcase
    end

    AST_EVAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (state == CH_EVAL) |=> (state != CH_EVAL)) else $error("evaluation lasted two cycles"); // R2
    AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) (state == CH_EVAL) |=> (($past(sample_q) >= $past(avg_q)) ? (avg_q >= $past(avg_q) && avg_q <= $past(sample_q)) : (avg_q <= $past(avg_q) && avg_q >= $past(sample_q)))) else $error("average left its range"); // R3
    AST_UP_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) up_run <= up_num) else $error("above run overflow"); // R4
    AST_DN_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) dn_run <= dn_num) else $error("below run overflow"); // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (stat_wr && (state != CH_EVAL)) |=> ((flags_q & $past(wdata[FLAG_LSB +: 4])) == 4'b0)) else $error("flag survived clear"); // R7
    AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (state == CH_OFF) |-> (acc_q == '0)) else $error("stopped channel counted"); // R9
    AST_AVG_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n) ((state == CH_OFF) && !(ctrl_wr && wdata[B_EN])) |=> $stable(avg_q)) else $error("stopped average moved"); // R9

endmodule

// File: rtl/am_activity_monitor.sv
module am_activity_monitor
    import am_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int PER_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ms_tick,
    input  logic [NUM_CH-1:0] ev_pulse,
    output logic              irq,
    output logic [NUM_CH-1:0] chan_pending
);

    localparam int REGION_W = ADDR_W - 8;

    wire [REGION_W-1:0] region = reg_addr[ADDR_W-1:8];
    wire [7:0]          offset = reg_addr[7:0];

    logic             period_end;
    logic [PER_W-1:0] period_q;
    logic [31:0]      ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;

    am_period_timer #(.PER_W(PER_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_wr     (reg_wr && (region == '0) && (offset == GOFF_PERIOD)),
        .per_wdata  (reg_wdata[PER_W-1:0]),
        .ms_tick    (ms_tick),
        .period_end (period_end),
        .period_q   (period_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        am_channel #(.DW(32)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (reg_wr && (region == REGION_W'(c + 1))),
            .offset     (offset),
            .wdata      (reg_wdata),
            .ev         (ev_pulse[c]),
            .period_end (period_end),
            .rdata      (ch_rdata[c]),
            .irq        (ch_irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (region == '0) begin
            if (offset == GOFF_PEND)        reg_rdata[NUM_CH-1:0] = ch_irq;
            else if (offset == GOFF_PERIOD) reg_rdata[PER_W-1:0]  = period_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (region == REGION_W'(c + 1)) reg_rdata = ch_rdata[c];
        end
    end

    assign chan_pending = ch_irq;
    assign irq          = |ch_irq;

endmodule

// File: tb/am_activity_monitor_tb_top.sv
`timescale 1ns/1ps
module am_activity_monitor_tb_top;

    localparam int NUM_CH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              ms_tick = 1'b0;
    logic [NUM_CH-1:0] ev_pulse = '0;
    logic              irq;
    logic [NUM_CH-1:0] chan_pending;

    always #10 clk = ~clk;

    am_activity_monitor #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_tick(ms_tick),
        .ev_pulse(ev_pulse), .irq(irq), .chan_pending(chan_pending)
    );

    typedef struct {
        int          kind;   // 0 register read, 1 irq, 2 pending word
        logic [31:0] expv;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    event req_ev;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // monitor: pops expected items and compares them with the design
    initial begin
        forever begin
            @(req_ev);
            #2;
            while (sbq.size() > 0) begin
                exp_t        e;
                logic [31:0] act;
                e = sbq.pop_front();
                case (e.kind)
                    0:       act = reg_rdata;
                    1:       act = {31'b0, irq};
                    default: act = {30'b0, chan_pending};
                endcase
                total++;
                if (act !== e.expv) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.expv);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [11:0] addr,
                               input logic [31:0] expv, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = addr;
        e.kind = kind;
        e.expv = expv;
        e.tag  = tag;
        sbq.push_back(e);
        -> req_ev;
        #5;
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic events(input int n0, input int n1);
        for (int i = 0; i < ((n0 > n1) ? n0 : n1); i++) begin
            @(negedge clk);
            ev_pulse = {(i < n1), (i < n0)};
            @(negedge clk);
            ev_pulse = '0;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic period(input int n0, input int n1);
        events(n0, n1);
        tick();
        tick();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 12'h100, 32'h0, "R1 ch0 control");
        expect_item(0, 12'h124, 32'h0, "R1 ch0 status");
        expect_item(0, 12'h000, 32'h0, "R1 pending register");
        expect_item(1, 12'h000, 32'h0, "R1 irq");
        expect_item(2, 12'h000, 32'h0, "R1 pending port");

        // channel 0: K=0, above run 1 period, below run 3 periods
        wr(12'h104, 32'd50);
        wr(12'h108, 32'd20);
        wr(12'h10C, 32'd40);
        wr(12'h110, 32'd100);
        wr(12'h114, 32'd5);
        wr(12'h118, 32'd10);
        wr(12'h100, 32'hE134_0000);
        // channel 1: K=1, no flags possible
        wr(12'h204, 32'hFFFF_FFFF);
        wr(12'h208, 32'd0);
        wr(12'h20C, 32'd0);
        wr(12'h210, 32'hFFFF_FFFF);
        wr(12'h214, 32'd0);
        wr(12'h218, 32'd8);
        wr(12'h200, 32'h8004_0400);
        wr(12'h004, 32'd1);   // two ticks per period

        expect_item(0, 12'h120, 32'd40, "R3 average loaded on enable");
        expect_item(0, 12'h004, 32'd1, "R2 period register");

        // P1: 60 on ch0, 40 on ch1
        events(6, 5);
        tick();
        expect_item(0, 12'h120, 32'd40, "R2 one tick does not close period");
        expect_item(1, 12'h000, 32'h0, "R2 no irq before period close");
        tick();
        expect_item(0, 12'h124, 32'h8000_0000, "R4 consecutive upper flag");
        expect_item(0, 12'h120, 32'd50, "R3 K=0 average step");
        expect_item(0, 12'h220, 32'd10, "R3 K=1 average step");
        expect_item(1, 12'h000, 32'h1, "R7 irq from enabled flag");
        expect_item(2, 12'h000, 32'h1, "R8 pending port ch0");
        expect_item(0, 12'h000, 32'h1, "R8 pending register ch0");

        wr(12'h200, 32'h8000_0400);   // ch1 periodic off
        wr(12'h124, 32'hFFFF_FFFF);
        expect_item(0, 12'h124, 32'h0, "R7 status cleared");
        expect_item(1, 12'h000, 32'h0, "R7 irq drops after clear");

        period(1, 0);
        period(1, 0);
        expect_item(0, 12'h124, 32'h0, "R5 two below periods no flag");
        period(3, 0);
        expect_item(0, 12'h120, 32'd25, "R3 average rises");
        period(1, 0);
        period(1, 0);
        expect_item(0, 12'h124, 32'h0, "R5 run restarted after non-breach");
        period(1, 0);
        expect_item(0, 12'h124, 32'h4000_0000, "R5 consecutive lower flag");
        expect_item(0, 12'h120, 32'd11, "R3 signed average decay");
        expect_item(1, 12'h000, 32'h1, "R5 irq from lower flag");

        wr(12'h124, 32'hFFFF_FFFF);
        wr(12'h114, 32'd12);
        period(1, 0);
        expect_item(0, 12'h124, 32'h1000_0000, "R6 average below watermark flag");
        expect_item(0, 12'h120, 32'd10, "R6 new average compared");
        expect_item(1, 12'h000, 32'h1, "R6 irq from average flag");
        expect_item(0, 12'h220, 32'd10, "R10 non-periodic channel average held");

        // R9 stop
        wr(12'h100, 32'h0);
        expect_item(1, 12'h000, 32'h0, "R9 stopped channel no irq");
        expect_item(2, 12'h000, 32'h0, "R9 stopped channel not pending");
        period(6, 0);
        expect_item(0, 12'h120, 32'd10, "R9 average held while stopped");
        expect_item(0, 12'h124, 32'h1000_0000, "R9 flags kept while stopped");
        expect_item(0, 12'h000, 32'h0, "R9 pending register clear");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule